// File: doc/BRIEF.md
# Multi-Port Bridge Reset Controller

This block sequences reset for a bridge that has one upstream bus and two independent downstream buses. Its upstream reset input is active low and asynchronous. From it the block derives reset-release signals for the core clock and the downstream clock. Each release asserts at once and deasserts in step with its clock. The block also holds off configuration access for a fixed number of upstream clock cycles after reset is released.

Each downstream bus has its own reset output. That output is modelled as an open-drain pull-low request. Two sources can drive it: the upstream reset, or a per-port control bit. The block also senses each downstream reset pin, which can be pulled low externally. When a port is in reset, its control outputs lose their enables at once, with no clock involved. Its address/data, byte-enable and parity lines are held low rather than floated. The other port is not affected.

The tri-state pads, the register file and the bus engines are outside this block. The block drives only the enable and force-low controls for them.

Top module: `bridge_rst_ctrl`

## Requirements
- R1: `core_rst_no` and `sclk_rst_no` go low in the same timestep as `rst_ni` falls. After `rst_ni` rises, each goes high on the 2nd rising edge of its own clock (`clk_i` and `sclk_i` respectively).
- R2: While `rst_ni` is low, the following hold with no clock edge needed: `up_oe_o`, `dn_ctl_oe_o`, `dn_data_oe_o`, `dn_force_low_o` and `cfg_ready_o` are all 0, and every bit of `dn_rst_drive_o` is 1.
- R3: Bit p of `dn_rst_drive_o` is 1 (pull the port-p reset pin low) for as long as bit p of `sec_rst_bit_i` is 1. It returns to 0 when the bit is cleared, provided `rst_ni` is high.
- R4: `cfg_ready_o` is 0 after the 224th rising `clk_i` edge that follows the release of `rst_ni`. It is 1 after the 225th such edge. It then stays 1 until `rst_ni` is asserted again.
- R5: If `rst_ni` is reasserted while the hold-off count is in progress, the count restarts from zero. After the next release, `cfg_ready_o` again rises on exactly the 225th edge.
- R6: A low level on bit p of `dn_rst_pin_ni` clears bit p of `dn_ctl_oe_o` in the same timestep, with no clock edge.
- R7: Port p is in reset when `rst_ni` is high and either bit p of `sec_rst_bit_i` is 1 or bit p of `dn_rst_pin_ni` is 0. While port p is in reset, bits p of `dn_force_low_o` and `dn_data_oe_o` are 1. Outside reset, bit p of `dn_force_low_o` is 0.
- R8: A reset on one downstream port leaves the other port's enables, force-low and reset-drive bits unchanged.
- R9: With `rst_ni` released and no port in reset, the enables follow the synchronized releases. `up_oe_o` becomes 1 once `core_rst_no` is 1. Bits of `dn_ctl_oe_o` and `dn_data_oe_o` become 1 once `sclk_rst_no` is 1. `dn_force_low_o` and `dn_rst_drive_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Upstream core clock |
| sclk_i | input | 1 | Downstream bus clock |
| rst_ni | input | 1 | Asynchronous active-low upstream reset |
| sec_rst_bit_i | input | NPORT | Per-port secondary-reset control bits (bit p = port p) |
| dn_rst_pin_ni | input | NPORT | Sensed downstream reset pin levels, active low |
| core_rst_no | output | 1 | Reset release synchronized to clk_i |
| sclk_rst_no | output | 1 | Reset release synchronized to sclk_i |
| up_oe_o | output | 1 | Upstream bus output enable |
| dn_rst_drive_o | output | NPORT | 1 = pull downstream reset pin low |
| dn_ctl_oe_o | output | NPORT | Downstream control/grant output enables |
| dn_data_oe_o | output | NPORT | Downstream address/data, byte-enable, parity enables |
| dn_force_low_o | output | NPORT | Drive address/data, byte-enable, parity low |
| cfg_ready_o | output | 1 | Configuration access accepted |

## Verification
The assertions check, on every clock, the relations that hold at any instant. Upstream reset must quiet every enable and drive both reset pins. A set control bit must keep its port's reset drive on. A low pin must leave its port's controls off and force the data lines low. The ready flag must stay up once raised. Some properties depend on counting or on exact timing: the ready flag rising on exactly the 225th edge, the count restarting after an early reassertion, and the enables dropping within the same timestep as an asynchronous pin change. Those are shown only by the bench's directed scenarios.

// File: rtl/bridge_rst_pkg.sv
`timescale 1ns/1ps
package bridge_rst_pkg;
  typedef struct packed {
    logic rst_drive;
    logic ctl_oe;
    logic data_oe;
    logic force_low;
  } port_ctl_t;
endpackage

// File: rtl/brc_rst_sync.sv
`timescale 1ns/1ps
module brc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/brc_holdoff_cnt.sv
`timescale 1ns/1ps
module brc_holdoff_cnt #(
  parameter int HOLDOFF = 225,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,   // already synchronized release
  output logic ready_o
);
  // synchronizer latency is part of the hold-off window
  localparam int LIMIT = HOLDOFF - SYNC_STAGES;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/brc_port_gate.sv
`timescale 1ns/1ps
module brc_port_gate
  import bridge_rst_pkg::*;
(
  input  logic      up_rst_ni,  // raw, asynchronous
  input  logic      sclk_rel_i, // synchronized release, downstream clock
  input  logic      sec_bit_i,
  input  logic      pin_ni,
  output port_ctl_t ctl_o
);
  logic port_rst;

  assign port_rst        = sec_bit_i | ~pin_ni;
  assign ctl_o.rst_drive = ~up_rst_ni | sec_bit_i;
  assign ctl_o.force_low = up_rst_ni & port_rst;
  assign ctl_o.ctl_oe    = up_rst_ni & sclk_rel_i & ~port_rst;
  assign ctl_o.data_oe   = ctl_o.force_low | ctl_o.ctl_oe;
endmodule

// File: rtl/bridge_rst_ctrl.sv
`timescale 1ns/1ps
module bridge_rst_ctrl
  import bridge_rst_pkg::*;
#(
  parameter int NPORT       = 2,
  parameter int HOLDOFF     = 225,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             sclk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] sec_rst_bit_i,
  input  logic [NPORT-1:0] dn_rst_pin_ni,
  output logic             core_rst_no,
  output logic             sclk_rst_no,
  output logic             up_oe_o,
  output logic [NPORT-1:0] dn_rst_drive_o,
  output logic [NPORT-1:0] dn_ctl_oe_o,
  output logic [NPORT-1:0] dn_data_oe_o,
  output logic [NPORT-1:0] dn_force_low_o,
  output logic             cfg_ready_o
);
  brc_rst_sync #(.STAGES(SYNC_STAGES)) u_core_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(core_rst_no)
  );

  brc_rst_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk_i(sclk_i), .rst_ni(rst_ni), .rst_no(sclk_rst_no)
  );

  brc_holdoff_cnt #(.HOLDOFF(HOLDOFF), .SYNC_STAGES(SYNC_STAGES)) u_holdoff (
    .clk_i(clk_i), .rst_ni(core_rst_no), .ready_o(cfg_ready_o)
  );

  assign up_oe_o = rst_ni & core_rst_no;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    port_ctl_t ctl;
    brc_port_gate u_gate (
      .up_rst_ni (rst_ni),
      .sclk_rel_i(sclk_rst_no),
      .sec_bit_i (sec_rst_bit_i[p]),
      .pin_ni    (dn_rst_pin_ni[p]),
      .ctl_o     (ctl)
    );
    assign dn_rst_drive_o[p] = ctl.rst_drive;
    assign dn_ctl_oe_o[p]    = ctl.ctl_oe;
    assign dn_data_oe_o[p]   = ctl.data_oe;
    assign dn_force_low_o[p] = ctl.force_low;
  end
endmodule

// File: rtl/bridge_rst_ctrl_chk.sv
`timescale 1ns/1ps
module bridge_rst_ctrl_chk #(
  parameter int NPORT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPORT-1:0] sec_rst_bit_i,
  input logic [NPORT-1:0] dn_rst_pin_ni,
  input logic             core_rst_no,
  input logic             up_oe_o,
  input logic [NPORT-1:0] dn_rst_drive_o,
  input logic [NPORT-1:0] dn_ctl_oe_o,
  input logic [NPORT-1:0] dn_data_oe_o,
  input logic [NPORT-1:0] dn_force_low_o,
  input logic             cfg_ready_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_up_rst_quiet_R2: assert (!up_oe_o && dn_ctl_oe_o == '0 &&
        dn_data_oe_o == '0 && dn_force_low_o == '0 && !cfg_ready_o &&
        dn_rst_drive_o == {NPORT{1'b1}})
        else $error("upstream reset left an output active");
    end
  end

  assert_ready_needs_core_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ready_o || up_oe_o) |-> core_rst_no);

  assert_ready_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ready_o |=> cfg_ready_o);

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    assert_sec_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sec_rst_bit_i[p] |-> dn_rst_drive_o[p]);

    assert_pin_ctl_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dn_rst_pin_ni[p] |-> !dn_ctl_oe_o[p]);

    assert_force_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dn_rst_pin_ni[p] |-> (dn_force_low_o[p] && dn_data_oe_o[p]));
  end
endmodule

bind bridge_rst_ctrl bridge_rst_ctrl_chk #(.NPORT(NPORT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sec_rst_bit_i (sec_rst_bit_i),
  .dn_rst_pin_ni (dn_rst_pin_ni),
  .core_rst_no   (core_rst_no),
  .up_oe_o       (up_oe_o),
  .dn_rst_drive_o(dn_rst_drive_o),
  .dn_ctl_oe_o   (dn_ctl_oe_o),
  .dn_data_oe_o  (dn_data_oe_o),
  .dn_force_low_o(dn_force_low_o),
  .cfg_ready_o   (cfg_ready_o)
);

// File: tb/bridge_rst_ctrl_bench.sv
`timescale 1ns/1ps
module bridge_rst_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 2;

  logic clk = 1'b0, sclk = 1'b0, rst_n = 1'b0;
  logic [NPORT-1:0] sec_bit = '0, ext_rst = '0;
  wire  [NPORT-1:0] pin_n;
  logic core_rst_n, sclk_rst_n, up_oe, ready;
  logic [NPORT-1:0] drive, ctl_oe, data_oe, force_low;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin
    #2;
    forever #(CLK_PERIOD/2) sclk = ~sclk;
  end

  // open-drain pin: low if the block or an external agent pulls it
  assign pin_n = ~(drive | ext_rst);

  bridge_rst_ctrl #(.NPORT(NPORT)) u_bridge_rst_ctrl (
    .clk_i(clk), .sclk_i(sclk), .rst_ni(rst_n),
    .sec_rst_bit_i(sec_bit), .dn_rst_pin_ni(pin_n),
    .core_rst_no(core_rst_n), .sclk_rst_no(sclk_rst_n), .up_oe_o(up_oe),
    .dn_rst_drive_o(drive), .dn_ctl_oe_o(ctl_oe), .dn_data_oe_o(data_oe),
    .dn_force_low_o(force_low), .cfg_ready_o(ready)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R2 up_oe in reset", up_oe, 0);
    chk("R2 ctl_oe in reset", ctl_oe, 0);
    chk("R2 data_oe in reset", data_oe, 0);
    chk("R2 force_low in reset", force_low, 0);
    chk("R2 drive in reset", drive, 2'b11);
    chk("R2 ready in reset", ready, 0);
    chk("R1 core release low", core_rst_n, 0);
    chk("R1 sclk release low", sclk_rst_n, 0);
  endtask

  task automatic t_sync_release();
    release_reset();
    @(posedge clk); #1 chk("R1 core after edge 1", core_rst_n, 0);
    @(posedge clk); #1 chk("R1 core after edge 2", core_rst_n, 1);
    chk("R9 up_oe follows core release", up_oe, 1);
  endtask

  task automatic t_holdoff();
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 core drops at once", core_rst_n, 0);
    repeat (3) @(negedge clk);
    release_reset();
    repeat (224) @(posedge clk);
    #1 chk("R4 ready after edge 224", ready, 0);
    @(posedge clk);
    #1 chk("R4 ready after edge 225", ready, 1);
    repeat (20) @(posedge clk);
    #1 chk("R4 ready stays high", ready, 1);
  endtask

  task automatic t_restart();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    release_reset();
    repeat (100) @(posedge clk);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R5 ready low on reassert", ready, 0);
    @(negedge clk);
    release_reset();
    repeat (224) @(posedge clk);
    #1 chk("R5 restarted count edge 224", ready, 0);
    @(posedge clk);
    #1 chk("R5 restarted count edge 225", ready, 1);
  endtask

  task automatic t_normal();
    @(negedge clk);
    chk("R9 ctl_oe normal", ctl_oe, 2'b11);
    chk("R9 data_oe normal", data_oe, 2'b11);
    chk("R9 force_low normal", force_low, 0);
    chk("R9 drive normal", drive, 0);
    chk("R9 up_oe normal", up_oe, 1);
  endtask

  task automatic t_sec_bit();
    @(negedge clk); sec_bit[1] = 1'b1;
    #1;
    chk("R3 drive set", drive[1], 1);
    chk("R7 force_low port1", force_low[1], 1);
    chk("R7 data_oe port1", data_oe[1], 1);
    chk("R8 port0 ctl untouched", ctl_oe[0], 1);
    chk("R8 port0 force untouched", force_low[0], 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R3 drive persists", drive[1], 1);
      chk("R3 ctl stays off", ctl_oe[1], 0);
    end
    sec_bit[1] = 1'b0;
    #1;
    chk("R3 drive released", drive[1], 0);
    chk("R3 ctl restored", ctl_oe[1], 1);
    chk("R7 force_low cleared", force_low[1], 0);
  endtask

  task automatic t_pin_async();
    realtime t0;
    @(negedge clk);
    #2;
    t0 = $realtime;
    ext_rst[0] = 1'b1;
    wait (ctl_oe[0] == 1'b0);
    chk("R6 ctl_oe drop same timestep", ($realtime == t0) ? 1 : 0, 1);
    #1;
    chk("R7 force_low pin reset", force_low[0], 1);
    chk("R7 data_oe pin reset", data_oe[0], 1);
    chk("R8 port1 ctl untouched", ctl_oe[1], 1);
    chk("R8 port1 drive untouched", drive[1], 0);
    chk("R8 port1 force untouched", force_low[1], 0);
    @(negedge clk); ext_rst[0] = 1'b0;
    #1 chk("R6 ctl_oe back after pin release", ctl_oe[0], 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset_state();
    t_sync_release();
    t_holdoff();
    t_restart();
    t_normal();
    t_sec_bit();
    t_pin_async();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule